// File: doc/BRIEF.md
# Multi-Supply Reset Sequencer

This block is the digital core of a power-on and brown-out reset supervisor. Four external comparators, already synchronised to the block clock, each raise one undervoltage flag when their supply is below its trip point. The block merges those flags with three other reset causes:

- a deglitched, active-low manual reset button input;
- a one-cycle watchdog-expired request;
- its own synchronous initialisation.

From these it drives a single reset pin. A fault of any kind pulls reset in on the next clock edge. Reset lets go only after a hold interval in which no fault has been seen. The hold length is picked with a 2-bit select, and every new fault during the hold restarts the count from zero.

A watchdog request that arrives while reset is released produces exactly one reset pulse, one hold interval long. The pin can be built as open-drain active-low, push-pull active-low or push-pull active-high. In the open-drain build it is described by a constant low data bit plus an output enable. All durations are clock-cycle counts derived from the `CLK_HZ` parameter.

Top module: `reset_sequencer`

## Requirements
- R1: When any bit of `sup_uv` is 1 (supply below threshold) at a clock edge, reset is asserted after that edge.
- R2: Once all causes are clear, reset stays asserted for exactly L clock edges and then releases. L = (CLK_HZ/1000) x {50, 100, 200, 400} for `tsel` = 0, 1, 2, 3.
- R3: If a supply flag or the manual reset becomes active again during the hold, the hold restarts, and release comes L edges after the newest fault clears.
- R4: A low level on `mr_n` lasting at least MR_FILT_CYC consecutive clock edges is recognised. Reset is asserted MR_FILT_CYC+3 edges after the first low sample.
- R5: A low pulse on `mr_n` shorter than MR_FILT_CYC clock edges has no effect on the reset output.
- R6: After `mr_n` returns high, reset is released MR_FILT_CYC+2+L edges after the first high sample.
- R7: A `wdt_expired` pulse seen while reset is released gives one reset pulse of exactly L edges. Further requests during an active reset neither extend nor retrigger it.
- R8: Reset is asserted while `rst_n` is low. After `rst_n` goes high with no fault, reset releases after exactly L edges.
- R9: Pin encoding by OUT_MODE:
  - 0 (open drain): `rst_out`=0 and `rst_oe`=1 while asserted, `rst_oe`=0 while released.
  - 1 (push-pull, active low): `rst_out`=0 while asserted, `rst_oe`=1.
  - 2 (push-pull, active high): `rst_out`=1 while asserted, `rst_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Synchronous initialisation, active low |
| sup_uv | input | 4 | Synchronised undervoltage flags, 1 = supply low |
| mr_n | input | 1 | Raw manual reset input, active low |
| wdt_expired | input | 1 | Watchdog-expired request, one-cycle pulse |
| tsel | input | 2 | Hold length select (0: 50 ms, 1: 100 ms, 2: 200 ms, 3: 400 ms) |
| rst_out | output | 1 | Reset pin data level |
| rst_oe | output | 1 | Reset pin output enable |

## Verification
Each supply flag is faulted on its own, with a different hold select each time. This shows both that every lane reaches the reset and that each code maps to its own length. A fault that reappears midway through a hold tells a restarting counter apart from one that merely pauses or carries on. Manual reset pulses of MR_FILT_CYC-1 cycles, exactly MR_FILT_CYC cycles and many cycles pin down the filter threshold and its latency. A second watchdog request inside a watchdog pulse separates a fixed-length pulse from a retriggerable one. Two instances with different pin modes watch the same stimulus, so the polarity encodings are compared edge for edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        OUT_OD_LOW  = 2'd0,
        OUT_PP_LOW  = 2'd1,
        OUT_PP_HIGH = 2'd2
    } out_mode_e;

    // Hold length in clock cycles for a 2-bit select code.
    function automatic int hold_cycles(input int clk_hz, input logic [1:0] code);
        int ms;
        case (code)
            2'd0:    ms = 50;
            2'd1:    ms = 100;
            2'd2:    ms = 200;
            default: ms = 400;
        endcase
        return (clk_hz / 1000) * ms;
    endfunction

endpackage

// File: rtl/rstseq_mr_filter.sv
module rstseq_mr_filter #(
    parameter int FILT_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n_raw,
    output logic mr_active
);
    localparam int FW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [FW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d    = flt_q;
        flt_d.s1 = mr_n_raw;
        flt_d.s2 = flt_q.s1;
        if (flt_q.s2 != flt_q.lvl) begin
            if (flt_q.cnt == FW'(FILT_CYC - 1)) begin
                flt_d.lvl = flt_q.s2;
                flt_d.cnt = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_q <= '{s1: 1'b1, s2: 1'b1, lvl: 1'b1, cnt: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign mr_active = ~flt_q.lvl;

    // R5: the filtered level only ever moves to the synchronised input value
    a_r5_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_q.lvl) |-> flt_q.lvl == $past(flt_q.s2));

endmodule

// File: rtl/rstseq_hold_ctrl.sv
module rstseq_hold_ctrl #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault,
    input  logic       wdt_req,
    input  logic [1:0] tsel,
    output logic       asserted
);
    localparam int MAX_HOLD = rstseq_pkg::hold_cycles(CLK_HZ, 2'd3);
    localparam int CW       = $clog2(MAX_HOLD + 1);

    typedef struct packed {
        logic          asserted;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t         hld_d, hld_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = CW'(rstseq_pkg::hold_cycles(CLK_HZ, tsel));
    end

    always_comb begin
        hld_d = hld_q;
        if (fault) begin
            hld_d.asserted = 1'b1;
            hld_d.cnt      = '0;
        end else if (hld_q.asserted) begin
            if (hld_q.cnt >= limit - 1'b1) begin
                hld_d.asserted = 1'b0;
                hld_d.cnt      = '0;
            end else begin
                hld_d.cnt = hld_q.cnt + 1'b1;
            end
        end else if (wdt_req) begin
            hld_d.asserted = 1'b1;
            hld_d.cnt      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hld_q <= '{asserted: 1'b1, cnt: '0};
        end else begin
            hld_q <= hld_d;
        end
    end

    assign asserted = hld_q.asserted;

    // R3: a fault during the hold clears the count and keeps reset in
    a_r3_fault_restarts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (hld_q.cnt == '0) && hld_q.asserted);

    // R8: initialisation leaves reset asserted with an empty count
    a_r8_init_asserts: assert property (@(posedge clk)
        !rst_n |=> hld_q.asserted && (hld_q.cnt == '0));

endmodule

// File: rtl/rstseq_out_stage.sv
module rstseq_out_stage #(
    parameter rstseq_pkg::out_mode_e OUT_MODE = rstseq_pkg::OUT_OD_LOW
) (
    input  logic asserted,
    output logic pin_lvl,
    output logic pin_oe
);
    generate
        if (OUT_MODE == rstseq_pkg::OUT_OD_LOW) begin : g_od
            assign pin_lvl = 1'b0;
            assign pin_oe  = asserted;
        end else if (OUT_MODE == rstseq_pkg::OUT_PP_LOW) begin : g_pp_low
            assign pin_lvl = ~asserted;
            assign pin_oe  = 1'b1;
        end else begin : g_pp_high
            assign pin_lvl = asserted;
            assign pin_oe  = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
    parameter int                    CLK_HZ      = 50_000_000,
    parameter int                    NUM_SUP     = 4,
    parameter int                    MR_FILT_CYC = ((CLK_HZ / 2_000_000) < 2) ? 2 : (CLK_HZ / 2_000_000),
    parameter rstseq_pkg::out_mode_e OUT_MODE    = rstseq_pkg::OUT_OD_LOW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SUP-1:0] sup_uv,
    input  logic               mr_n,
    input  logic               wdt_expired,
    input  logic [1:0]         tsel,
    output logic               rst_out,
    output logic               rst_oe
);
    logic mr_active;
    logic fault;
    logic asserted;

    rstseq_mr_filter #(
        .FILT_CYC (MR_FILT_CYC)
    ) u_mr_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .mr_n_raw  (mr_n),
        .mr_active (mr_active)
    );

    always_comb begin
        fault = (|sup_uv) | mr_active;
    end

    rstseq_hold_ctrl #(
        .CLK_HZ (CLK_HZ)
    ) u_hold_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (fault),
        .wdt_req  (wdt_expired),
        .tsel     (tsel),
        .asserted (asserted)
    );

    rstseq_out_stage #(
        .OUT_MODE (OUT_MODE)
    ) u_out_stage (
        .asserted (asserted),
        .pin_lvl  (rst_out),
        .pin_oe   (rst_oe)
    );

    // R1: any low supply forces reset on the following edge
    a_r1_supply_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        (|sup_uv) |=> asserted);

    // R4: a recognised manual reset forces reset on the following edge
    a_r4_manual_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        mr_active |=> asserted);

    // R2: release only happens after an edge with every cause clear
    a_r2_release_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asserted) |-> ($past(sup_uv) == '0) && !$past(mr_active));

endmodule

// File: tb/reset_sequencer_tb_top.sv
module reset_sequencer_tb_top;
    localparam int CLK_HZ_TB = 20_000;
    localparam int FILT      = 8;
    localparam int WATCHDOG  = 200_000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] sup_uv;
    logic       mr_n;
    logic       wdt_expired;
    logic [1:0] tsel;
    logic       od_out, od_oe, hi_out, hi_oe;

    int cyc    = 0;
    int checks = 0;
    int fails  = 0;

    typedef struct {
        int    at;
        bit    lvl;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    reset_sequencer #(
        .CLK_HZ      (CLK_HZ_TB),
        .MR_FILT_CYC (FILT),
        .OUT_MODE    (rstseq_pkg::OUT_OD_LOW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .sup_uv (sup_uv), .mr_n (mr_n),
        .wdt_expired (wdt_expired), .tsel (tsel),
        .rst_out (od_out), .rst_oe (od_oe)
    );

    reset_sequencer #(
        .CLK_HZ      (CLK_HZ_TB),
        .MR_FILT_CYC (FILT),
        .OUT_MODE    (rstseq_pkg::OUT_PP_HIGH)
    ) dut_hi_i (
        .clk (clk), .rst_n (rst_n), .sup_uv (sup_uv), .mr_n (mr_n),
        .wdt_expired (wdt_expired), .tsel (tsel),
        .rst_out (hi_out), .rst_oe (hi_oe)
    );

    function automatic int hold_len(input int code);
        int ms;
        ms = (code == 0) ? 50 : (code == 1) ? 100 : (code == 2) ? 200 : 400;
        return (CLK_HZ_TB / 1000) * ms;
    endfunction

    task automatic push_exp(input int at, input bit lvl, input string tag);
        exp_t e;
        e.at  = at;
        e.lvl = lvl;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares both pin modes against the expected reset state (R9 encoding)
    always @(negedge clk) begin
        while (sb.size() != 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.at != cyc) begin
                fails++;
                $display("FAIL %s: check missed, actual cycle=%0d expected cycle=%0d", e.tag, cyc, e.at);
            end else if (od_oe !== e.lvl || od_out !== 1'b0) begin
                fails++;
                $display("FAIL %s/R9 open-drain at cycle %0d: actual oe=%b out=%b expected oe=%b out=0",
                         e.tag, cyc, od_oe, od_out, e.lvl);
            end
            checks++;
            if (hi_out !== e.lvl || hi_oe !== 1'b1) begin
                fails++;
                $display("FAIL %s/R9 active-high at cycle %0d: actual out=%b oe=%b expected out=%b oe=1",
                         e.tag, cyc, hi_out, hi_oe, e.lvl);
            end
        end
    end

    task automatic finish_run();
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL pending: actual %0d unchecked items expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..: actual running after %0d cycles expected done", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c;
        int d;
        int e;
        int L;
        rst_n       = 1'b0;
        sup_uv      = '0;
        mr_n        = 1'b1;
        wdt_expired = 1'b0;
        tsel        = 2'd0;

        // R8: asserted during init, released L edges after it ends
        tick(2);
        push_exp(cyc + 1, 1'b1, "R8");
        tick(3);
        c = cyc;
        rst_n = 1'b1;
        L = hold_len(0);
        push_exp(c + L - 1, 1'b1, "R8");
        push_exp(c + L, 1'b0, "R8");
        tick(L + 4);

        // R1 and R2: each supply lane with a different hold select
        for (int i = 0; i < 4; i++) begin
            tsel = 2'(i);
            L = hold_len(i);
            c = cyc;
            sup_uv[i] = 1'b1;
            push_exp(c + 1, 1'b1, "R1");
            tick(3);
            d = cyc;
            sup_uv[i] = 1'b0;
            push_exp(d + L - 1, 1'b1, "R2");
            push_exp(d + L, 1'b0, "R2");
            tick(L + 3);
        end

        // R3: fault reappears midway through the hold
        tsel = 2'd0;
        L = hold_len(0);
        sup_uv = 4'b0100;
        tick(2);
        d = cyc;
        sup_uv = '0;
        tick(500);
        e = cyc;
        sup_uv = 4'b0010;
        push_exp(d + L, 1'b1, "R3");
        push_exp(e + L, 1'b1, "R3");
        push_exp(e + 1 + L, 1'b0, "R3");
        tick(1);
        sup_uv = '0;
        tick(L + 4);

        // R4 and R6: long manual reset press
        c = cyc;
        mr_n = 1'b0;
        push_exp(c + FILT + 2, 1'b0, "R4");
        push_exp(c + FILT + 3, 1'b1, "R4");
        tick(40);
        d = cyc;
        mr_n = 1'b1;
        push_exp(d + FILT + 1 + L, 1'b1, "R6");
        push_exp(d + FILT + 2 + L, 1'b0, "R6");
        tick(L + FILT + 5);

        // R5: pulse one cycle short of the filter length is ignored
        c = cyc;
        for (int k = 1; k <= 40; k++) push_exp(c + k, 1'b0, "R5");
        mr_n = 1'b0;
        tick(FILT - 1);
        mr_n = 1'b1;
        tick(45);

        // R4: pulse of exactly the filter length is recognised
        c = cyc;
        mr_n = 1'b0;
        push_exp(c + FILT + 3, 1'b1, "R4");
        tick(FILT);
        mr_n = 1'b1;
        push_exp(c + 2 * FILT + 1 + L, 1'b1, "R6");
        push_exp(c + 2 * FILT + 2 + L, 1'b0, "R6");
        tick(L + 2 * FILT + 5);

        // R7: watchdog pulse of fixed length, second request ignored
        tsel = 2'd1;
        L = hold_len(1);
        c = cyc;
        wdt_expired = 1'b1;
        push_exp(c + 1, 1'b1, "R7");
        push_exp(c + L, 1'b1, "R7");
        push_exp(c + 1 + L, 1'b0, "R7");
        push_exp(c + 11 + L, 1'b0, "R7");
        tick(1);
        wdt_expired = 1'b0;
        tick(100);
        wdt_expired = 1'b1;
        tick(1);
        wdt_expired = 1'b0;
        tick(L + 20);

        finish_run();
    end

endmodule